// File: doc/BRIEF.md
# MII Ethernet Frame Receiver

This block takes the 4-bit receive side of a media-independent interface, clocked by the PHY receive clock, and turns each received frame into a byte-wide AXI4-Stream. Nibbles arrive one per clock, low nibble of each byte first. The block searches the nibble stream for the start-of-frame delimiter and discards everything up to and including it. From the first destination-address byte onward it packs nibble pairs into bytes and streams them out.

A CRC-32 runs over every byte after the delimiter. The last four bytes of a frame are the frame check sequence. A short delay line keeps them off the stream, so `tlast` marks the last payload byte and that beat also carries the verdict on `tuser`. The frame verdict is also given as single-cycle error pulses. The output has no ready input. The consumer must accept a beat on every cycle that `tvalid` is high.

Top module: `mii_frame_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `m_axis_tvalid`, `m_axis_tlast`, `m_axis_tuser`, `err_bad_frame` and `err_bad_fcs` are 0 until a frame arrives.
- R2: Nibbles are paired low-first into bytes. The byte phase starts with the nibble after the delimiter pair (nibble 0x5 followed by nibble 0xD). No preamble or delimiter byte appears on the stream, and the first beat is the first byte after the delimiter.
- R3: The stream carries every byte after the delimiter except the final four, in arrival order. `m_axis_tlast` is 1 only on the last carried byte. A frame with one byte before its check sequence yields exactly one beat, and that beat has `tlast` set.
- R4: A frame whose check sequence matches the reflected CRC-32 of its bytes (polynomial 0xEDB88320, seed all ones, final inversion, sent least significant byte first) ends with `tuser` 0 and no error pulse.
- R5: On a check-sequence mismatch, `err_bad_fcs` and `err_bad_frame` each pulse for one cycle, in the same cycle as the `tlast` beat, and that beat has `tuser` 1.
- R6: If `mii_rx_er` is high in any cycle while `mii_rx_dv` is high, the frame is bad: `tuser` is 1 on `tlast` and `err_bad_frame` pulses. `err_bad_fcs` stays 0 if the CRC is good.
- R7: If `mii_rx_dv` falls after an odd number of nibbles past the delimiter, the trailing half byte is dropped and the frame is reported bad on `tuser` and `err_bad_frame`.
- R8: Nibbles received before a delimiter produce no beat and no pulse. This applies to a burst with no delimiter at all and to noise that comes before the preamble.
- R9: A frame with four or fewer bytes after the delimiter produces no beat, and `err_bad_frame` pulses once.
- R10: `mii_rx_er` while `mii_rx_dv` is low has no effect on the next frame.
- R11: Frames separated by a short idle gap are each delimited, checked and streamed independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PHY receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mii_rxd | input | 4 | Receive nibble |
| mii_rx_dv | input | 1 | Receive data valid |
| mii_rx_er | input | 1 | PHY-signalled receive error |
| m_axis_tdata | output | 8 | Stream byte |
| m_axis_tvalid | output | 1 | Stream beat valid (no backpressure) |
| m_axis_tlast | output | 1 | Last beat of the frame |
| m_axis_tuser | output | 1 | Bad-frame flag, valid on the tlast beat |
| err_bad_frame | output | 1 | One-cycle pulse for any bad frame |
| err_bad_fcs | output | 1 | One-cycle pulse on a check-sequence mismatch |

## Verification
A wrong byte phase or a missed delimiter shows at the ports in the first beat of the frame: every byte comes out as a swapped nibble pair, or the frame is lost. A wrong fill count in the delay line moves `tlast` and lets check-sequence bytes onto the stream, and this is seen on the frame's final beat a few cycles after `mii_rx_dv` falls. A wrong CRC state or a sticky error flag does not show until the verdict at the end of that frame, or at the end of the next frame if the flag is not cleared. For that reason the bench sends a clean frame right after each error case.

// File: rtl/mfr_pkg.sv
// Shared constants and types for the MII frame receiver.
// Assumes 4-bit nibbles; delimiter detection uses the nibble pair below.
package mfr_pkg;

    // Receive assembler states.
    typedef enum logic [1:0] {
        ASM_IDLE = 2'd0,
        ASM_HUNT = 2'd1,
        ASM_DATA = 2'd2
    } asm_state_t;

    // Preamble nibble and high nibble of the start delimiter.
    localparam logic [3:0] PRE_NIB = 4'h5;
    localparam logic [3:0] SFD_HI  = 4'hD;

    // Reflected CRC-32 settings.
    localparam logic [31:0] CRC_POLY_REF = 32'hEDB88320;
    localparam logic [31:0] CRC_RESIDUE  = 32'hDEBB20E3;

endpackage

// File: rtl/mfr_in_reg.sv
// Input capture stage: registers the nibble bus and its qualifiers once
// on the PHY receive clock. Assumes inputs are already timed to clk.
module mfr_in_reg #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] rxd_i,
    input  logic             dv_i,
    input  logic             er_i,
    output logic [NIB_W-1:0] nib_o,
    output logic             dv_o,
    output logic             er_o
);

    // Capture the PHY pins into flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_o <= '0;
            dv_o  <= 1'b0;
            er_o  <= 1'b0;
        end else begin
            nib_o <= rxd_i;
            dv_o  <= dv_i;
            er_o  <= er_i;
        end
    end

endmodule

// File: rtl/mfr_nibble_asm.sv
// Nibble assembler: searches for the delimiter nibble pair, then packs
// nibbles low-first into bytes. Signals frame start, byte strobes and frame
// end with a bad flag (odd nibble count or error seen while dv was high).
// Assumes one nibble per clock while dv is high.
module mfr_nibble_asm
    import mfr_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  nib_i,
    input  logic              dv_i,
    input  logic              er_i,
    output logic              f_start_o,
    output logic              b_vld_o,
    output logic [BYTE_W-1:0] b_data_o,
    output logic              f_end_o,
    output logic              f_bad_o
);

    asm_state_t       state;
    logic             last_pre;
    logic             phase;
    logic             err_seen;
    logic [NIB_W-1:0] lo_nib;

    // Delimiter search, nibble pairing and end-of-frame reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ASM_IDLE;
            last_pre  <= 1'b0;
            phase     <= 1'b0;
            err_seen  <= 1'b0;
            lo_nib    <= '0;
            f_start_o <= 1'b0;
            b_vld_o   <= 1'b0;
            b_data_o  <= '0;
            f_end_o   <= 1'b0;
            f_bad_o   <= 1'b0;
        end else begin
            f_start_o <= 1'b0;
            b_vld_o   <= 1'b0;
            f_end_o   <= 1'b0;
            f_bad_o   <= 1'b0;
            if (!dv_i) begin
                if (state == ASM_DATA) begin
                    f_end_o <= 1'b1;
                    f_bad_o <= phase | err_seen;
                end
                state    <= ASM_IDLE;
                last_pre <= 1'b0;
                phase    <= 1'b0;
                err_seen <= 1'b0;
            end else begin
                err_seen <= err_seen | er_i;
                case (state)
                    ASM_IDLE, ASM_HUNT: begin
                        if (last_pre && nib_i == NIB_W'(SFD_HI)) begin
                            state     <= ASM_DATA;
                            phase     <= 1'b0;
                            f_start_o <= 1'b1;
                        end else begin
                            state <= ASM_HUNT;
                        end
                        last_pre <= (nib_i == NIB_W'(PRE_NIB));
                    end
                    default: begin
                        if (!phase) begin
                            lo_nib <= nib_i;
                            phase  <= 1'b1;
                        end else begin
                            b_vld_o  <= 1'b1;
                            b_data_o <= {nib_i, lo_nib};
                            phase    <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    // R2
    byte_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_vld_o |=> !b_vld_o);

    // R2
    start_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_start_o |=> !b_vld_o);

    // R8
    end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_end_o |=> !f_end_o);

endmodule

// File: rtl/mfr_crc_chk.sv
// Running reflected CRC over received bytes. It is seeded on frame start
// and flags a match when the register holds the good-frame residue.
// Assumes bytes arrive no faster than one per clock.
module mfr_crc_chk #(
    parameter int                BYTE_W  = 8,
    parameter int                CRC_W   = 32,
    parameter logic [CRC_W-1:0]  POLY    = mfr_pkg::CRC_POLY_REF,
    parameter logic [CRC_W-1:0]  RESIDUE = mfr_pkg::CRC_RESIDUE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              f_start_i,
    input  logic              b_vld_i,
    input  logic [BYTE_W-1:0] b_data_i,
    output logic              crc_ok_o
);

    logic [CRC_W-1:0] crc_q;

    // Advance the CRC by one byte, LSB first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c ^ {{(CRC_W-BYTE_W){1'b0}}, d};
        for (int i = 0; i < BYTE_W; i++) begin
            r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
        end
        return r;
    endfunction

    // Seed on frame start, otherwise fold in each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (f_start_i) begin
            crc_q <= '1;
        end else if (b_vld_i) begin
            crc_q <= crc_step(crc_q, b_data_i);
        end
    end

    assign crc_ok_o = (crc_q == RESIDUE);

endmodule

// File: rtl/mfr_holdback.sv
// Holdback and stream output: a HOLD-byte delay line keeps the check
// sequence off the stream, and one pending register holds the newest
// releasable byte until it is known whether it is the last one. Emits the
// verdict on tuser at tlast and as error pulses. Assumes no backpressure.
module mfr_holdback #(
    parameter int BYTE_W = 8,
    parameter int HOLD   = 4,
    localparam int FILL_W = $clog2(HOLD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              f_start_i,
    input  logic              b_vld_i,
    input  logic [BYTE_W-1:0] b_data_i,
    input  logic              f_end_i,
    input  logic              f_bad_i,
    input  logic              crc_ok_i,
    output logic [BYTE_W-1:0] m_tdata_o,
    output logic              m_tvalid_o,
    output logic              m_tlast_o,
    output logic              m_tuser_o,
    output logic              bad_frame_o,
    output logic              bad_fcs_o
);

    logic [BYTE_W-1:0] dly [HOLD];
    logic [FILL_W-1:0] fill;
    logic              pend_vld;
    logic [BYTE_W-1:0] pend_data;
    logic              full;
    logic              bad_now;

    assign full    = (fill == FILL_W'(HOLD));
    assign bad_now = f_bad_i | ~crc_ok_i | ~pend_vld;

    // Delay line stages, shifted on each received byte.
    for (genvar g = 0; g < HOLD; g++) begin : g_stage
        if (g == 0) begin : g_head
            // Head stage takes the incoming byte.
            always_ff @(posedge clk) begin
                if (!rst_n)       dly[g] <= '0;
                else if (b_vld_i) dly[g] <= b_data_i;
            end
        end else begin : g_body
            // Later stages take the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n)       dly[g] <= '0;
                else if (b_vld_i) dly[g] <= dly[g-1];
            end
        end
    end

    // Fill tracking, pending byte and beat/verdict generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill        <= '0;
            pend_vld    <= 1'b0;
            pend_data   <= '0;
            m_tdata_o   <= '0;
            m_tvalid_o  <= 1'b0;
            m_tlast_o   <= 1'b0;
            m_tuser_o   <= 1'b0;
            bad_frame_o <= 1'b0;
            bad_fcs_o   <= 1'b0;
        end else begin
            m_tvalid_o  <= 1'b0;
            m_tlast_o   <= 1'b0;
            m_tuser_o   <= 1'b0;
            bad_frame_o <= 1'b0;
            bad_fcs_o   <= 1'b0;
            if (f_start_i) begin
                fill     <= '0;
                pend_vld <= 1'b0;
            end else if (b_vld_i) begin
                if (full) begin
                    pend_data <= dly[HOLD-1];
                    pend_vld  <= 1'b1;
                    if (pend_vld) begin
                        m_tvalid_o <= 1'b1;
                        m_tdata_o  <= pend_data;
                    end
                end else begin
                    fill <= fill + 1'b1;
                end
            end else if (f_end_i) begin
                bad_frame_o <= bad_now;
                bad_fcs_o   <= ~crc_ok_i;
                if (pend_vld) begin
                    m_tvalid_o <= 1'b1;
                    m_tdata_o  <= pend_data;
                    m_tlast_o  <= 1'b1;
                    m_tuser_o  <= bad_now;
                end
                pend_vld <= 1'b0;
                fill     <= '0;
            end
        end
    end

    // R3
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(HOLD));

    // R3
    user_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tuser_o |-> (m_tvalid_o && m_tlast_o));

    // R5
    fcs_implies_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_fcs_o |-> bad_frame_o);

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_frame_o |=> !bad_frame_o);

    // R4
    verdict_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid_o && m_tlast_o) |-> (m_tuser_o == bad_frame_o));

endmodule

// File: rtl/mii_frame_rx.sv
// MII frame receiver top: input capture, nibble assembler, CRC checker and
// holdback/output stage in a three-register pipeline. Assumes one nibble
// per PHY clock and a consumer that never stalls.
module mii_frame_rx #(
    parameter int NIB_W     = 4,
    parameter int FCS_BYTES = 4,
    parameter int CRC_W     = 32,
    localparam int BYTE_W   = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  mii_rxd,
    input  logic              mii_rx_dv,
    input  logic              mii_rx_er,
    output logic [BYTE_W-1:0] m_axis_tdata,
    output logic              m_axis_tvalid,
    output logic              m_axis_tlast,
    output logic              m_axis_tuser,
    output logic              err_bad_frame,
    output logic              err_bad_fcs
);

    logic [NIB_W-1:0]  nib_q;
    logic              dv_q;
    logic              er_q;
    logic              f_start;
    logic              b_vld;
    logic [BYTE_W-1:0] b_data;
    logic              f_end;
    logic              f_bad;
    logic              crc_ok;

    mfr_in_reg #(.NIB_W(NIB_W)) u_in (
        .clk   (clk),
        .rst_n (rst_n),
        .rxd_i (mii_rxd),
        .dv_i  (mii_rx_dv),
        .er_i  (mii_rx_er),
        .nib_o (nib_q),
        .dv_o  (dv_q),
        .er_o  (er_q)
    );

    mfr_nibble_asm #(.NIB_W(NIB_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib_i     (nib_q),
        .dv_i      (dv_q),
        .er_i      (er_q),
        .f_start_o (f_start),
        .b_vld_o   (b_vld),
        .b_data_o  (b_data),
        .f_end_o   (f_end),
        .f_bad_o   (f_bad)
    );

    mfr_crc_chk #(.BYTE_W(BYTE_W), .CRC_W(CRC_W)) u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .f_start_i (f_start),
        .b_vld_i   (b_vld),
        .b_data_i  (b_data),
        .crc_ok_o  (crc_ok)
    );

    mfr_holdback #(.BYTE_W(BYTE_W), .HOLD(FCS_BYTES)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .f_start_i   (f_start),
        .b_vld_i     (b_vld),
        .b_data_i    (b_data),
        .f_end_i     (f_end),
        .f_bad_i     (f_bad),
        .crc_ok_i    (crc_ok),
        .m_tdata_o   (m_axis_tdata),
        .m_tvalid_o  (m_axis_tvalid),
        .m_tlast_o   (m_axis_tlast),
        .m_tuser_o   (m_axis_tuser),
        .bad_frame_o (err_bad_frame),
        .bad_fcs_o   (err_bad_fcs)
    );

endmodule

// File: tb/mii_frame_rx_tb.sv
module mii_frame_rx_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rxd = '0;
    logic       dv = 1'b0;
    logic       er = 1'b0;
    logic [7:0] tdata;
    logic       tvalid, tlast, tuser, bad_frame, bad_fcs;

    mii_frame_rx u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mii_rxd       (rxd),
        .mii_rx_dv     (dv),
        .mii_rx_er     (er),
        .m_axis_tdata  (tdata),
        .m_axis_tvalid (tvalid),
        .m_axis_tlast  (tlast),
        .m_axis_tuser  (tuser),
        .err_bad_frame (bad_frame),
        .err_bad_fcs   (bad_fcs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] frm [0:255];
    int         flen;
    logic [7:0] cap [0:255];
    logic       capl [0:255];
    logic       capu [0:255];
    int ncap, nlast, nfcs, nbad, nbad_last;

    // Monitor: record beats and pulses between edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tvalid && ncap < 256) begin
                cap[ncap]  = tdata;
                capl[ncap] = tlast;
                capu[ncap] = tuser;
                ncap++;
            end
            if (tvalid && tlast) nlast++;
            if (bad_fcs) nfcs++;
            if (bad_frame) nbad++;
            if (bad_frame && tvalid && tlast) nbad_last++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic mon_clear();
        ncap = 0; nlast = 0; nfcs = 0; nbad = 0; nbad_last = 0;
    endtask

    // Fill n data bytes and append the reference check sequence.
    task automatic build(input int n, input int seed, input bit with_fcs);
        logic [31:0] c;
        c = '1;
        for (int i = 0; i < n; i++) begin
            frm[i] = 8'((i * 13 + seed) & 8'hFF);
            c = c ^ {24'h0, frm[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        flen = n;
        if (with_fcs) begin
            for (int k = 0; k < 4; k++) frm[n+k] = c[8*k +: 8];
            flen = n + 4;
        end
    endtask

    task automatic drive_nib(input logic [3:0] nv, input logic ev);
        @(negedge clk);
        rxd = nv; dv = 1'b1; er = ev;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rxd = '0; dv = 1'b0; er = 1'b0;
        end
    endtask

    // Send noise, preamble, delimiter, frame bytes, optional extra nibble.
    task automatic send(input int er_nib, input bit extra, input int noise_n, input int gap);
        int k;
        for (int i = 0; i < noise_n; i++) drive_nib(4'((i % 4) + 1), 1'b0);
        for (int i = 0; i < 7; i++) begin
            drive_nib(4'h5, 1'b0); drive_nib(4'h5, 1'b0);
        end
        drive_nib(4'h5, 1'b0); drive_nib(4'hD, 1'b0);
        k = 0;
        for (int i = 0; i < flen; i++) begin
            drive_nib(frm[i][3:0], 1'(k == er_nib)); k++;
            drive_nib(frm[i][7:4], 1'(k == er_nib)); k++;
        end
        if (extra) drive_nib(4'hA, 1'b0);
        idle(gap);
    endtask

    // Compare the captured stream with frm[0..n-1].
    task automatic check_stream(input string tag, input int n, input int exp_user);
        int bad_d, bad_l;
        bad_d = 0; bad_l = 0;
        chk({tag, " beat count"}, ncap, n);
        for (int i = 0; i < n && i < ncap; i++) begin
            if (cap[i] != frm[i]) bad_d++;
            if (capl[i] != (i == n - 1)) bad_l++;
        end
        chk({tag, " data mismatches"}, bad_d, 0);
        chk({tag, " tlast placement errors"}, bad_l, 0);
        if (ncap > 0) chk({tag, " tuser on last"}, int'(capu[ncap-1]), exp_user);
    endtask

    task automatic t_reset();
        chk("R1 tvalid in reset", int'(tvalid), 0);
        chk("R1 pulses in reset", int'(bad_frame | bad_fcs | tlast | tuser), 0);
        rst_n = 1'b1;
        idle(5);
        chk("R1 tvalid after reset", int'(tvalid), 0);
        chk("R1 no activity after reset", ncap + nbad + nfcs, 0);
    endtask

    task automatic t_good();
        mon_clear(); build(40, 3, 1); send(-1, 0, 0, 14);
        check_stream("R2 R3 R4 good frame", 40, 0);
        chk("R4 no fcs pulse", nfcs, 0);
        chk("R4 no bad pulse", nbad, 0);
    endtask

    task automatic t_min();
        mon_clear(); build(1, 77, 1); send(-1, 0, 0, 14);
        check_stream("R3 single-byte frame", 1, 0);
        chk("R3 single beat tlast count", nlast, 1);
    endtask

    task automatic t_badfcs();
        mon_clear(); build(30, 5, 1); frm[flen-1] = frm[flen-1] ^ 8'h01;
        send(-1, 0, 0, 14);
        check_stream("R5 fcs mismatch", 30, 1);
        chk("R5 fcs pulse count", nfcs, 1);
        chk("R5 bad pulse count", nbad, 1);
        chk("R5 pulse with tlast", nbad_last, 1);
    endtask

    task automatic t_rxer();
        mon_clear(); build(24, 9, 1); send(10, 0, 0, 14);
        check_stream("R6 rx_er frame", 24, 1);
        chk("R6 bad pulse", nbad, 1);
        chk("R6 no fcs pulse", nfcs, 0);
    endtask

    task automatic t_odd();
        mon_clear(); build(16, 21, 1); send(-1, 1, 0, 14);
        check_stream("R7 odd nibble frame", 16, 1);
        chk("R7 bad pulse", nbad, 1);
        chk("R7 no fcs pulse", nfcs, 0);
    endtask

    task automatic t_noise();
        logic [3:0] seq [0:11];
        seq = '{4'h1, 4'h5, 4'h5, 4'h5, 4'hE, 4'hD, 4'h0, 4'h5, 4'hC, 4'hD, 4'h5, 4'h5};
        mon_clear();
        foreach (seq[i]) drive_nib(seq[i], 1'b0);
        idle(12);
        chk("R8 no beats from noise", ncap, 0);
        chk("R8 no pulses from noise", nbad + nfcs, 0);
        mon_clear(); build(12, 40, 1); send(-1, 0, 9, 14);
        check_stream("R8 noise before preamble", 12, 0);
        chk("R8 clean verdict", nbad, 0);
    endtask

    task automatic t_runt();
        mon_clear(); build(3, 1, 0); send(-1, 0, 0, 14);
        chk("R9 runt beats", ncap, 0);
        chk("R9 runt bad pulse", nbad, 1);
    endtask

    task automatic t_er_idle();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); dv = 1'b0; er = 1'b1; rxd = 4'hF;
        end
        idle(2);
        mon_clear(); build(20, 60, 1); send(-1, 0, 0, 14);
        check_stream("R10 er while idle", 20, 0);
        chk("R10 no pulses", nbad + nfcs, 0);
    endtask

    task automatic t_b2b();
        mon_clear();
        build(10, 90, 1); send(-1, 0, 0, 3);
        build(14, 11, 1); send(-1, 0, 0, 14);
        chk("R11 total beats", ncap, 24);
        chk("R11 tlast count", nlast, 2);
        chk("R11 no pulses", nbad + nfcs, 0);
        if (ncap == 24) begin
            chk("R11 first frame last beat", int'(capl[9]), 1);
            chk("R11 second frame tuser", int'(capu[23]), 0);
        end
    endtask

    initial begin
        mon_clear();
        repeat (4) @(negedge clk);
        t_reset();
        t_good();
        t_min();
        t_badfcs();
        t_rxer();
        t_odd();
        t_noise();
        t_runt();
        t_er_idle();
        t_b2b();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule